// File: doc/BRIEF.md
# Polling Bus Arbiter

This block decides which of several devices may drive a shared bus. Rather than giving each device its own grant wire, the arbiter broadcasts an encoded device number on a narrow poll-address bus, ceil(log2 N) bits wide. Each device that wants the bus asserts its request only while the bus is free; the OR of these requests forms a shared request line. When the arbiter sees that line high, it starts polling. It places one candidate index on the poll lines each clock. The first polled device that is still requesting takes the bus. Busy then goes high and that device's acquired bit is set.

The order of polling sets the priority and can be changed at run time through a mode input. In fixed order, polling always starts at index 0, so lower indices win. In rotating order, polling starts at the index after the previous owner, so every requester is reached in turn. The owner keeps the bus until it pulses its done input. The arbiter then drops busy, and a new poll round begins if any request is pending. The cost of this scheme is latency: a grant arrives two cycles after the request is first seen, plus one cycle for every candidate skipped.

Top module: `poll_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_busy_o is 0, acquired_o is all zeros and poll_addr_o is 0.
- R2: bus_req_o is 1 exactly when at least one bit of dev_req_i is set and the bus is not busy; while bus_busy_o is 1 it reads 0 even with requests held.
- R3: When the arbiter is idle and a request is present at a clock edge, poll_addr_o shows the start index after that edge. After each later edge without a grant, it shows the next index, wrapping from N_DEV-1 to 0.
- R4: With mode_rr_i = 0 (fixed order), the start index is 0, so the lowest-numbered requesting device wins. Busy rises at the (w+2)-th edge after the request appears, where w is the winner's index.
- R5: With mode_rr_i = 1 (rotating order), the start index is one past the most recent owner, modulo N_DEV; after reset the most recent owner counts as N_DEV-1. Busy rises at the (d+2)-th edge, where d is the winner's distance from the start index.
- R6: When the polled index belongs to a requesting device, the next edge sets bus_busy_o and sets acquired_o to the one-hot bit of that index. poll_addr_o then holds that index for as long as the bus stays busy.
- R7: A 1 on the owner's dev_done_i bit at an edge clears bus_busy_o and acquired_o after that edge. dev_done_i bits of devices that are not the owner have no effect.
- R8: If every request is withdrawn while polling, the arbiter returns to idle after the next edge without granting.
- R9: At most one bit of acquired_o is ever set, and bus_busy_o equals the OR of acquired_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_rr_i | input | 1 | 0 = fixed order from index 0, 1 = rotating order after last owner |
| dev_req_i | input | N_DEV | Per-device bus request |
| dev_done_i | input | N_DEV | Per-device release pulse, honoured for the owner only |
| bus_req_o | output | 1 | Shared request line, OR of requests while bus is free |
| bus_busy_o | output | 1 | Shared busy line, high while a device owns the bus |
| poll_addr_o | output | IDX_W | Encoded device number being polled or holding the bus |
| acquired_o | output | N_DEV | One-hot owner indication |

## Verification
The bench builds the arbiter with N_DEV = 5. Five is not a power of two, so the three-bit poll address must wrap at 4 and never reach the unused codes 5 to 7. Five devices also keep the space small enough to sweep all 31 non-empty request patterns in both modes. For each pattern the bench computes the winner, the exact grant cycle and the whole poll-address trajectory arithmetically. In rotating mode it carries the last owner from one pattern to the next, so the start index itself is exercised at every position.

// File: rtl/pa_pkg.sv
package pa_pkg;

    typedef int unsigned uidx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_POLL = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_e;

    // Next candidate index, wrapping at the device count.
    function automatic uidx_t wrap_inc(input uidx_t idx, input uidx_t n);
        return (idx + 1 >= n) ? uidx_t'(0) : idx + 1;
    endfunction

endpackage

// File: rtl/pa_start_sel.sv
module pa_start_sel #(
    parameter int N_DEV = 5,
    parameter int IDX_W = 3
) (
    input  logic             rr_mode,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] start_idx
);
    import pa_pkg::*;

    generate
        if (N_DEV == 1) begin : g_single
            assign start_idx = '0;
        end else begin : g_multi
            always_comb begin
                if (rr_mode)
                    start_idx = IDX_W'(wrap_inc(uidx_t'(last_idx), uidx_t'(N_DEV)));
                else
                    start_idx = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/pa_owner_dec.sv
module pa_owner_dec #(
    parameter int N_DEV = 5,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [N_DEV-1:0] onehot
);
    for (genvar g = 0; g < N_DEV; g++) begin : g_bit
        assign onehot[g] = en && (idx == IDX_W'(g));
    end

    // R9: never two owners at once
    p_single_owner_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(onehot));

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
    parameter  int N_DEV = 5,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_rr_i,
    input  logic [N_DEV-1:0] dev_req_i,
    input  logic [N_DEV-1:0] dev_done_i,
    output logic             bus_req_o,
    output logic             bus_busy_o,
    output logic [IDX_W-1:0] poll_addr_o,
    output logic [N_DEV-1:0] acquired_o
);
    import pa_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DEV - 1);

    arb_state_e       state_q;
    logic [IDX_W-1:0] poll_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] next_idx;
    logic             any_req;
    logic             hit;
    logic             in_busy;

    assign any_req  = |dev_req_i;
    assign hit      = dev_req_i[poll_q];
    assign in_busy  = (state_q == ST_BUSY);
    assign next_idx = IDX_W'(wrap_inc(uidx_t'(poll_q), uidx_t'(N_DEV)));

    pa_start_sel #(.N_DEV(N_DEV), .IDX_W(IDX_W)) start_i (
        .rr_mode   (mode_rr_i),
        .last_idx  (last_q),
        .start_idx (start_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            poll_q  <= '0;
            last_q  <= LAST_IDX;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        state_q <= ST_POLL;
                        poll_q  <= start_idx;
                    end
                end
                ST_POLL: begin
                    if (!any_req) begin
                        state_q <= ST_IDLE;
                    end else if (hit) begin
                        state_q <= ST_BUSY;
                        last_q  <= poll_q;
                    end else begin
                        poll_q  <= next_idx;
                    end
                end
                ST_BUSY: begin
                    if (dev_done_i[poll_q])
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    pa_owner_dec #(.N_DEV(N_DEV), .IDX_W(IDX_W)) dec_i (
        .clk    (clk),
        .rst    (rst),
        .en     (in_busy),
        .idx    (poll_q),
        .onehot (acquired_o)
    );

    assign bus_busy_o  = in_busy;
    assign bus_req_o   = any_req && !in_busy;
    assign poll_addr_o = poll_q;

    // R2: the shared request line stays low while the bus is owned
    p_req_quiet_busy_r2: assert property (@(posedge clk) disable iff (rst)
        bus_busy_o |-> !bus_req_o);

    // R3: an unanswered poll moves on by one index
    p_poll_step_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && any_req && !hit) |=>
        (poll_addr_o == IDX_W'(wrap_inc(uidx_t'($past(poll_addr_o)), uidx_t'(N_DEV)))));

    // R6: a requesting polled device becomes the owner
    p_grant_polled_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POLL && any_req && hit) |=>
        (bus_busy_o && acquired_o == (N_DEV'(1) << $past(poll_addr_o))));

    // R6: the address holds on the owner while busy continues
    p_hold_owner_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_busy_o && !dev_done_i[poll_addr_o]) |=> (bus_busy_o && $stable(poll_addr_o)));

    // R7: owner release frees the bus
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_busy_o && dev_done_i[poll_addr_o]) |=> (!bus_busy_o && acquired_o == '0));

    // R3: the poll address never leaves the device range
    p_addr_range_r3: assert property (@(posedge clk) disable iff (rst)
        poll_addr_o <= LAST_IDX);

endmodule

// File: tb/poll_arbiter_tb_top.sv
`timescale 1ns/1ps
module poll_arbiter_tb_top;
    localparam int N = 5;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_rr = 1'b0;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_done = '0;
    logic         bus_req;
    logic         bus_busy;
    logic [W-1:0] poll_addr;
    logic [N-1:0] acquired;

    int n_chk = 0;
    int n_fail = 0;
    int last_owner = N - 1;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    poll_arbiter #(.N_DEV(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_rr_i   (mode_rr),
        .dev_req_i   (dev_req),
        .dev_done_i  (dev_done),
        .bus_req_o   (bus_req),
        .bus_busy_o  (bus_busy),
        .poll_addr_o (poll_addr),
        .acquired_o  (acquired)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full request/grant/release round for pattern p.
    task automatic round(input logic [N-1:0] p, input bit rr);
        int start;
        int d;
        int w;
        int cnt;
        start = rr ? (last_owner + 1) % N : 0;
        d = -1;
        for (int k = 0; k < N; k++) begin
            if (d < 0 && p[(start + k) % N]) d = k;
        end
        w = (start + d) % N;
        mode_rr = rr;
        dev_req = p;
        #1;
        chk(bus_req == 1'b1, "R2 req line idle", int'(bus_req), 1);
        cnt = 0;
        while (!bus_busy && cnt < 3 * N) begin
            step();
            cnt++;
            if (!bus_busy) begin
                chk(poll_addr == W'((start + cnt - 1) % N), "R3 poll addr",
                    int'(poll_addr), (start + cnt - 1) % N);
                chk(bus_req == 1'b1, "R2 req line polling", int'(bus_req), 1);
            end
        end
        chk(cnt == d + 2, rr ? "R5 grant latency" : "R4 grant latency", cnt, d + 2);
        chk(acquired == N'(1) << w, "R6 acquired one-hot", int'(acquired), 1 << w);
        chk(poll_addr == W'(w), rr ? "R5 winner" : "R4 winner", int'(poll_addr), w);
        chk(bus_req == 1'b0, "R2 req line busy", int'(bus_req), 0);
        last_owner = w;
        // done from every other device must be ignored
        dev_done = ~(N'(1) << w);
        step();
        chk(bus_busy == 1'b1, "R7 foreign done ignored", int'(bus_busy), 1);
        chk(poll_addr == W'(w), "R6 addr held", int'(poll_addr), w);
        dev_done = N'(1) << w;
        dev_req = '0;
        step();
        dev_done = '0;
        chk(bus_busy == 1'b0, "R7 release busy", int'(bus_busy), 0);
        chk(acquired == '0, "R7 release acquired", int'(acquired), 0);
        chk(bus_busy == |acquired, "R9 busy vs acquired", int'(bus_busy), int'(|acquired));
    endtask

    initial begin
        repeat (3) step();
        chk(bus_busy == 1'b0, "R1 busy in reset", int'(bus_busy), 0);
        chk(acquired == '0, "R1 acquired in reset", int'(acquired), 0);
        rst = 1'b0;
        step();
        chk(poll_addr == '0, "R1 poll addr", int'(poll_addr), 0);
        chk(bus_busy == 1'b0, "R1 busy after reset", int'(bus_busy), 0);

        // idle with no requests
        repeat (3) step();
        chk(bus_req == 1'b0 && bus_busy == 1'b0, "R2 no request idle", int'(bus_req), 0);

        // fixed order sweep over every pattern
        for (int p = 1; p < (1 << N); p++) round(N'(p), 1'b0);
        // rotating order sweep, twice to move the start point around
        for (int rep = 0; rep < 2; rep++)
            for (int p = 1; p < (1 << N); p++) round(N'(p), 1'b1);

        // R8: withdraw during polling
        mode_rr = 1'b0;
        dev_req = N'(1) << (N - 1);
        step();
        step();
        chk(poll_addr == W'(1), "R3 poll before withdraw", int'(poll_addr), 1);
        dev_req = '0;
        step();
        chk(bus_busy == 1'b0, "R8 withdraw no grant", int'(bus_busy), 0);
        repeat (N) step();
        chk(bus_busy == 1'b0 && acquired == '0, "R8 stays idle", int'(acquired), 0);
        // arbiter still usable afterwards
        round(N'(5'b01000), 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule